// File: doc/BRIEF.md
# Halt and Shutdown Controller

This block holds the power and exception state of a processor core. The core can be running, halted or shut down. A halt-instruction strobe starts a two-step bus handshake. First the block requests a halt bus cycle. Once the bus acknowledges it, the block requests a stop-grant bus cycle and, if the configuration allows, enters a low-power suspend. A triple-fault strobe moves the core into shutdown.

Wake-up events are the reset request, the system-management interrupt, the non-maskable interrupt and the maskable interrupt. Each state accepts a different set of them. Shutdown accepts only reset, or an NMI when the descriptor-table limit and the stack pointer leave room to deliver it. On every wake the block pulses a valid strobe with a cause code and gives the address to resume at. Instruction decode, fault detection and the interrupt dispatch itself are outside this block.

Top module: `hsc_top`

## Requirements
- R1: After the asynchronous reset, haltCycle, stopGrantCycle, suspendOut, shutdownOut and wakeValid are 0, wakeCause is 0 and resumeIp equals RESET_VEC.
- R2: In the running state, haltInstr sampled high at a clock edge makes haltCycle high for exactly the following clock cycle, and nextIp is captured at that edge.
- R3: stopGrantCycle goes high for one cycle only after the edge at which busAck is sampled high while the halt cycle awaits acknowledgement. A busAck seen in the running state has no effect.
- R4: suspendOut rises together with stopGrantCycle when suspOnHalt is 1 at that edge, and stays 0 when suspOnHalt is 0.
- R5: In the halted state, resetReq, smiReq or nmiReq each wake the core. intrReq wakes it only while intEnable is 1. A wake pulses wakeValid for one cycle and clears suspendOut at the same edge.
- R6: When several wake requests are present together, the cause is chosen in the order reset (code 1), SMI (code 2), NMI (code 3), INTR (code 4).
- R7: On a non-reset wake from halt, resumeIp equals the nextIp captured with the halt instruction. On a reset wake it equals RESET_VEC.
- R8: In the running state, tripleFault sampled high sets shutdownOut at the next edge and takes precedence over a simultaneous haltInstr.
- R9: In shutdown, smiReq and intrReq are ignored. nmiReq wakes the core (cause 3) only when idtLimit >= NMI_MIN_LIMIT (000Fh) and stackPtr > NMI_MIN_SP (5). Otherwise shutdownOut stays 1 and wakeValid stays 0.
- R10: resetReq in any state returns the core to running with wakeValid, cause 1, and clears shutdownOut and suspendOut.
- R11: While the halt cycle awaits acknowledgement, SMI, NMI and INTR requests do not wake the core. A request still held once the core is halted wakes it at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| haltInstr | input | 1 | Halt instruction retired strobe |
| nextIp | input | IP_W | Address of the instruction after the halt |
| tripleFault | input | 1 | Triple fault detected strobe |
| resetReq | input | 1 | Core reset request |
| smiReq | input | 1 | System-management interrupt request |
| nmiReq | input | 1 | Non-maskable interrupt request |
| intrReq | input | 1 | Maskable interrupt request |
| intEnable | input | 1 | Interrupt-enable flag |
| suspOnHalt | input | 1 | Enter suspend after stop-grant when 1 |
| idtLimit | input | LIM_W | Interrupt descriptor table limit |
| stackPtr | input | SP_W | Current stack pointer |
| busAck | input | 1 | Bus acknowledges the halt cycle |
| haltCycle | output | 1 | Halt bus cycle request, one clock |
| stopGrantCycle | output | 1 | Stop-grant bus cycle request, one clock |
| suspendOut | output | 1 | Low-power suspend active |
| shutdownOut | output | 1 | Core is in shutdown |
| wakeValid | output | 1 | Wake event taken, one clock |
| wakeCause | output | 3 | Cause of the wake: 1 reset, 2 SMI, 3 NMI, 4 INTR |
| resumeIp | output | IP_W | Address to resume at |

## Verification
The halt path is driven with suspend enabled and with it disabled, and with an acknowledgement that arrives late, which separates the two bus strobes and the suspend choice. Wake-ups are tried with one request at a time, with INTR both masked and unmasked, and with every request at once, which exposes the priority order. The shutdown exit is tried with a table limit one below the threshold, with a stack pointer equal to the threshold and with both passing, which finds off-by-one comparisons. SMI held during the acknowledgement wait shows that the request is deferred and not lost.

// File: rtl/hsc_pkg.sv
package hsc_pkg;

  typedef enum logic [1:0] {
    ST_RUN      = 2'd0,
    ST_HALT_ACK = 2'd1,
    ST_HALTED   = 2'd2,
    ST_SHUT     = 2'd3
  } coreState_e;

  typedef enum logic [2:0] {
    WAKE_NONE  = 3'd0,
    WAKE_RESET = 3'd1,
    WAKE_SMI   = 3'd2,
    WAKE_NMI   = 3'd3,
    WAKE_INTR  = 3'd4
  } wakeCause_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       issueHalt;
    logic       issueStopGrant;
    logic       enterSuspend;
    logic       wake;
    wakeCause_e cause;
    logic       enterShutdown;
  } ctrlStrobe_t;

  // qualified wake causes from datapath to control
  typedef struct packed {
    wakeCause_e haltWake;
    wakeCause_e shutWake;
    logic       resetEv;
  } wakeSel_t;

endpackage

// File: rtl/hsc_event_qual.sv
module hsc_event_qual
  import hsc_pkg::*;
#(
  parameter int LIM_W         = 16,
  parameter int SP_W          = 32,
  parameter int NMI_MIN_LIMIT = 15,
  parameter int NMI_MIN_SP    = 5
) (
  input  logic             resetReq,
  input  logic             smiReq,
  input  logic             nmiReq,
  input  logic             intrReq,
  input  logic             intEnable,
  input  logic [LIM_W-1:0] idtLimit,
  input  logic [SP_W-1:0]  stackPtr,
  output wakeSel_t         sel
);

  localparam logic [LIM_W-1:0] LIMIT_MIN = LIM_W'(NMI_MIN_LIMIT);
  localparam logic [SP_W-1:0]  SP_MIN    = SP_W'(NMI_MIN_SP);

  logic limitOk;
  logic stackOk;
  logic intrLive;

  assign limitOk  = (idtLimit >= LIMIT_MIN);
  assign stackOk  = (stackPtr > SP_MIN);
  assign intrLive = intrReq & intEnable;

  always_comb begin
    sel = '{haltWake: WAKE_NONE, shutWake: WAKE_NONE, resetEv: resetReq};
    // halted state: fixed priority reset > smi > nmi > intr
    if (resetReq)      sel.haltWake = WAKE_RESET;
    else if (smiReq)   sel.haltWake = WAKE_SMI;
    else if (nmiReq)   sel.haltWake = WAKE_NMI;
    else if (intrLive) sel.haltWake = WAKE_INTR;
    // shutdown state: reset, or nmi with room to deliver it
    if (resetReq)                          sel.shutWake = WAKE_RESET;
    else if (nmiReq && limitOk && stackOk) sel.shutWake = WAKE_NMI;
  end

endmodule

// File: rtl/hsc_ctrl.sv
module hsc_ctrl
  import hsc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        haltInstr,
  input  logic        tripleFault,
  input  logic        busAck,
  input  logic        suspOnHalt,
  input  wakeSel_t    sel,
  output ctrlStrobe_t strobe
);

  coreState_e state;
  coreState_e stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '{issueHalt: 1'b0, issueStopGrant: 1'b0, enterSuspend: 1'b0,
                  wake: 1'b0, cause: WAKE_NONE, enterShutdown: 1'b0};
    unique case (state)
      ST_RUN: begin
        if (sel.resetEv) begin
          strobe.wake  = 1'b1;
          strobe.cause = WAKE_RESET;
        end else if (tripleFault) begin
          stateNext            = ST_SHUT;
          strobe.enterShutdown = 1'b1;
        end else if (haltInstr) begin
          stateNext        = ST_HALT_ACK;
          strobe.issueHalt = 1'b1;
        end
      end
      ST_HALT_ACK: begin
        if (sel.resetEv) begin
          stateNext    = ST_RUN;
          strobe.wake  = 1'b1;
          strobe.cause = WAKE_RESET;
        end else if (busAck) begin
          stateNext             = ST_HALTED;
          strobe.issueStopGrant = 1'b1;
          strobe.enterSuspend   = suspOnHalt;
        end
      end
      ST_HALTED: begin
        if (sel.haltWake != WAKE_NONE) begin
          stateNext    = ST_RUN;
          strobe.wake  = 1'b1;
          strobe.cause = sel.haltWake;
        end
      end
      ST_SHUT: begin
        if (sel.shutWake != WAKE_NONE) begin
          stateNext    = ST_RUN;
          strobe.wake  = 1'b1;
          strobe.cause = sel.shutWake;
        end
      end
      default: stateNext = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_RUN;
    else        state <= stateNext;
  end

endmodule

// File: rtl/hsc_dpath.sv
module hsc_dpath
  import hsc_pkg::*;
#(
  parameter int          IP_W      = 32,
  parameter logic [IP_W-1:0] RESET_VEC = '1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  ctrlStrobe_t     strobe,
  input  logic [IP_W-1:0] nextIp,
  output logic            haltCycle,
  output logic            stopGrantCycle,
  output logic            suspendOut,
  output logic            shutdownOut,
  output logic            wakeValid,
  output logic [2:0]      wakeCause,
  output logic [IP_W-1:0] resumeIp
);

  logic [IP_W-1:0] savedIp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      haltCycle      <= 1'b0;
      stopGrantCycle <= 1'b0;
      wakeValid      <= 1'b0;
      wakeCause      <= 3'(WAKE_NONE);
    end else begin
      haltCycle      <= strobe.issueHalt;
      stopGrantCycle <= strobe.issueStopGrant;
      wakeValid      <= strobe.wake;
      wakeCause      <= strobe.wake ? 3'(strobe.cause) : 3'(WAKE_NONE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     suspendOut <= 1'b0;
    else if (strobe.wake)           suspendOut <= 1'b0;
    else if (strobe.issueStopGrant) suspendOut <= strobe.enterSuspend;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    shutdownOut <= 1'b0;
    else if (strobe.enterShutdown) shutdownOut <= 1'b1;
    else if (strobe.wake)          shutdownOut <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                savedIp <= RESET_VEC;
    else if (strobe.issueHalt) savedIp <= nextIp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) resumeIp <= RESET_VEC;
    else if (strobe.wake)
      resumeIp <= (strobe.cause == WAKE_RESET) ? RESET_VEC : savedIp;
  end

endmodule

// File: rtl/hsc_top.sv
module hsc_top
  import hsc_pkg::*;
#(
  parameter int              IP_W          = 32,
  parameter int              LIM_W         = 16,
  parameter int              SP_W          = 32,
  parameter int              NMI_MIN_LIMIT = 15,
  parameter int              NMI_MIN_SP    = 5,
  parameter logic [IP_W-1:0] RESET_VEC     = 32'hFFFF_FFF0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             haltInstr,
  input  logic [IP_W-1:0]  nextIp,
  input  logic             tripleFault,
  input  logic             resetReq,
  input  logic             smiReq,
  input  logic             nmiReq,
  input  logic             intrReq,
  input  logic             intEnable,
  input  logic             suspOnHalt,
  input  logic [LIM_W-1:0] idtLimit,
  input  logic [SP_W-1:0]  stackPtr,
  input  logic             busAck,
  output logic             haltCycle,
  output logic             stopGrantCycle,
  output logic             suspendOut,
  output logic             shutdownOut,
  output logic             wakeValid,
  output logic [2:0]       wakeCause,
  output logic [IP_W-1:0]  resumeIp
);

  wakeSel_t    sel;
  ctrlStrobe_t strobe;

  hsc_event_qual #(
    .LIM_W(LIM_W), .SP_W(SP_W),
    .NMI_MIN_LIMIT(NMI_MIN_LIMIT), .NMI_MIN_SP(NMI_MIN_SP)
  ) u_qual (
    .resetReq(resetReq), .smiReq(smiReq), .nmiReq(nmiReq),
    .intrReq(intrReq), .intEnable(intEnable),
    .idtLimit(idtLimit), .stackPtr(stackPtr), .sel(sel)
  );

  hsc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .haltInstr(haltInstr),
    .tripleFault(tripleFault), .busAck(busAck),
    .suspOnHalt(suspOnHalt), .sel(sel), .strobe(strobe)
  );

  hsc_dpath #(.IP_W(IP_W), .RESET_VEC(RESET_VEC)) u_dpath (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .nextIp(nextIp),
    .haltCycle(haltCycle), .stopGrantCycle(stopGrantCycle),
    .suspendOut(suspendOut), .shutdownOut(shutdownOut),
    .wakeValid(wakeValid), .wakeCause(wakeCause), .resumeIp(resumeIp)
  );

endmodule

// File: rtl/hsc_checker.sv
module hsc_checker #(
  parameter int LIM_W         = 16,
  parameter int SP_W          = 32,
  parameter int NMI_MIN_LIMIT = 15,
  parameter int NMI_MIN_SP    = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             resetReq,
  input logic             nmiReq,
  input logic [LIM_W-1:0] idtLimit,
  input logic [SP_W-1:0]  stackPtr,
  input logic             haltCycle,
  input logic             stopGrantCycle,
  input logic             suspendOut,
  input logic             shutdownOut,
  input logic             wakeValid,
  input logic [2:0]       wakeCause
);

  logic haltPend;
  logic nmiFits;

  assign nmiFits = (idtLimit >= LIM_W'(NMI_MIN_LIMIT)) && (stackPtr > SP_W'(NMI_MIN_SP));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          haltPend <= 1'b0;
    else if (haltCycle)                  haltPend <= 1'b1;
    else if (stopGrantCycle || wakeValid) haltPend <= 1'b0;
  end

  AST_HALT_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    haltCycle |=> !haltCycle); // R2
  AST_SG_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    stopGrantCycle |=> !stopGrantCycle); // R3
  AST_SG_AFTER_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    stopGrantCycle |-> haltPend); // R3
  AST_SUSP_WITH_SG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(suspendOut) |-> stopGrantCycle); // R4
  AST_WAKE_DROPS_SUSP: assert property (@(posedge clk) disable iff (!rst_n)
    wakeValid |-> !suspendOut); // R5
  AST_CAUSE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    wakeValid |-> (wakeCause >= 3'd1 && wakeCause <= 3'd4)); // R6
  AST_SHUT_EXIT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shutdownOut) |-> (wakeValid && (wakeCause == 3'd1 || wakeCause == 3'd3))); // R9
  AST_SHUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (shutdownOut && !resetReq && !(nmiReq && nmiFits)) |=> shutdownOut); // R9
  AST_RESET_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
    resetReq |=> (wakeValid && wakeCause == 3'd1 && !shutdownOut)); // R10

endmodule

bind hsc_top hsc_checker #(
  .LIM_W(LIM_W), .SP_W(SP_W),
  .NMI_MIN_LIMIT(NMI_MIN_LIMIT), .NMI_MIN_SP(NMI_MIN_SP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .resetReq(resetReq), .nmiReq(nmiReq),
  .idtLimit(idtLimit), .stackPtr(stackPtr), .haltCycle(haltCycle),
  .stopGrantCycle(stopGrantCycle), .suspendOut(suspendOut),
  .shutdownOut(shutdownOut), .wakeValid(wakeValid), .wakeCause(wakeCause)
);

// File: tb/hsc_top_test.sv
`timescale 1ns/1ps
module hsc_top_test;

  localparam logic [31:0] RVEC = 32'hFFFF_FFF0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        haltInstr = 0, tripleFault = 0, resetReq = 0;
  logic        smiReq = 0, nmiReq = 0, intrReq = 0, intEnable = 0;
  logic        suspOnHalt = 0, busAck = 0;
  logic [31:0] nextIp = '0;
  logic [15:0] idtLimit = 16'h0100;
  logic [31:0] stackPtr = 32'h0000_1000;
  logic        haltCycle, stopGrantCycle, suspendOut, shutdownOut, wakeValid;
  logic [2:0]  wakeCause;
  logic [31:0] resumeIp;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  bit ended   = 0;

  always #2 clk = ~clk;

  hsc_top uut (
    .clk(clk), .rst_n(rst_n), .haltInstr(haltInstr), .nextIp(nextIp),
    .tripleFault(tripleFault), .resetReq(resetReq), .smiReq(smiReq),
    .nmiReq(nmiReq), .intrReq(intrReq), .intEnable(intEnable),
    .suspOnHalt(suspOnHalt), .idtLimit(idtLimit), .stackPtr(stackPtr),
    .busAck(busAck), .haltCycle(haltCycle), .stopGrantCycle(stopGrantCycle),
    .suspendOut(suspendOut), .shutdownOut(shutdownOut), .wakeValid(wakeValid),
    .wakeCause(wakeCause), .resumeIp(resumeIp)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  // one edge, then settle; inputs are changed after this returns
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
      finishRun();
    end
  end

  task automatic goHalted(input logic [31:0] ip, input logic susp);
    nextIp = ip; suspOnHalt = susp; haltInstr = 1;
    tick();
    haltInstr = 0; busAck = 1;
    tick();
    busAck = 0;
    tick();
  endtask

  task automatic tReset();
    check("R1", "haltCycle", 32'(haltCycle), 0);
    check("R1", "stopGrant", 32'(stopGrantCycle), 0);
    check("R1", "suspend", 32'(suspendOut), 0);
    check("R1", "shutdown", 32'(shutdownOut), 0);
    check("R1", "wakeValid", 32'(wakeValid), 0);
    check("R1", "wakeCause", 32'(wakeCause), 0);
    check("R1", "resumeIp", resumeIp, RVEC);
  endtask

  task automatic tHaltIntr();
    nextIp = 32'h0000_1234; suspOnHalt = 1; haltInstr = 1;
    tick();
    check("R2", "haltCycle pulse", 32'(haltCycle), 1);
    check("R3", "no early stop-grant", 32'(stopGrantCycle), 0);
    haltInstr = 0;
    tick();
    check("R2", "haltCycle one clock", 32'(haltCycle), 0);
    check("R3", "stop-grant waits ack", 32'(stopGrantCycle), 0);
    busAck = 1;
    tick();
    busAck = 0;
    check("R3", "stop-grant after ack", 32'(stopGrantCycle), 1);
    check("R4", "suspend with stop-grant", 32'(suspendOut), 1);
    intrReq = 1; intEnable = 0;
    tick();
    check("R3", "stop-grant one clock", 32'(stopGrantCycle), 0);
    tick();
    check("R5", "masked intr no wake", 32'(wakeValid), 0);
    check("R5", "masked intr keeps suspend", 32'(suspendOut), 1);
    intEnable = 1;
    tick();
    check("R5", "intr wakes", 32'(wakeValid), 1);
    check("R6", "intr cause", 32'(wakeCause), 4);
    check("R5", "suspend cleared", 32'(suspendOut), 0);
    check("R7", "resume after halt", resumeIp, 32'h0000_1234);
    intrReq = 0; intEnable = 0;
    tick();
    check("R5", "wake one clock", 32'(wakeValid), 0);
  endtask

  task automatic tNoSuspendNmi();
    nextIp = 32'h0000_2000; suspOnHalt = 0; haltInstr = 1;
    tick();
    haltInstr = 0; busAck = 1;
    tick();
    busAck = 0;
    check("R4", "stop-grant without suspend", 32'(stopGrantCycle), 1);
    check("R4", "suspend stays low", 32'(suspendOut), 0);
    tick();
    nmiReq = 1;
    tick();
    nmiReq = 0;
    check("R5", "nmi wakes", 32'(wakeValid), 1);
    check("R6", "nmi cause", 32'(wakeCause), 3);
    check("R7", "nmi resume", resumeIp, 32'h0000_2000);
    tick();
  endtask

  task automatic tAckInRun();
    busAck = 1;
    tick();
    busAck = 0;
    check("R3", "ack in run ignored", 32'(stopGrantCycle), 0);
    tick();
    check("R3", "ack in run still ignored", 32'(stopGrantCycle), 0);
  endtask

  task automatic tPriority();
    goHalted(32'h0000_3000, 1);
    smiReq = 1; nmiReq = 1; intrReq = 1; intEnable = 1;
    tick();
    smiReq = 0; nmiReq = 0; intrReq = 0; intEnable = 0;
    check("R6", "smi over nmi/intr", 32'(wakeCause), 2);
    check("R7", "smi resume", resumeIp, 32'h0000_3000);
    tick();
    goHalted(32'h0000_4000, 1);
    resetReq = 1; smiReq = 1; nmiReq = 1; intrReq = 1; intEnable = 1;
    tick();
    resetReq = 0; smiReq = 0; nmiReq = 0; intrReq = 0; intEnable = 0;
    check("R6", "reset over all", 32'(wakeCause), 1);
    check("R7", "reset resume vector", resumeIp, RVEC);
    check("R10", "reset clears suspend", 32'(suspendOut), 0);
    tick();
  endtask

  task automatic tPendingDuringAck();
    nextIp = 32'h0000_5000; suspOnHalt = 1; haltInstr = 1;
    tick();
    haltInstr = 0; smiReq = 1;
    tick();
    check("R11", "smi during ack wait", 32'(wakeValid), 0);
    tick();
    check("R11", "smi still deferred", 32'(wakeValid), 0);
    busAck = 1;
    tick();
    busAck = 0;
    check("R11", "stop-grant despite smi", 32'(stopGrantCycle), 1);
    check("R11", "no wake at ack edge", 32'(wakeValid), 0);
    tick();
    smiReq = 0;
    check("R11", "held smi wakes", 32'(wakeValid), 1);
    check("R11", "held smi cause", 32'(wakeCause), 2);
    check("R5", "suspend dropped on wake", 32'(suspendOut), 0);
    tick();
  endtask

  task automatic tShutdown();
    tripleFault = 1; haltInstr = 1;
    tick();
    tripleFault = 0; haltInstr = 0;
    check("R8", "shutdown entered", 32'(shutdownOut), 1);
    check("R8", "no halt cycle", 32'(haltCycle), 0);
    smiReq = 1; intrReq = 1; intEnable = 1;
    tick();
    smiReq = 0; intrReq = 0; intEnable = 0;
    check("R9", "smi/intr ignored", 32'(wakeValid), 0);
    check("R9", "still shut", 32'(shutdownOut), 1);
    nmiReq = 1; idtLimit = 16'h000E; stackPtr = 32'h100;
    tick();
    check("R9", "nmi small limit", 32'(shutdownOut), 1);
    check("R9", "nmi small limit no wake", 32'(wakeValid), 0);
    idtLimit = 16'h000F; stackPtr = 32'h5;
    tick();
    check("R9", "nmi sp at bound", 32'(shutdownOut), 1);
    stackPtr = 32'h6;
    tick();
    nmiReq = 0;
    check("R9", "nmi wakes shutdown", 32'(wakeValid), 1);
    check("R9", "nmi cause", 32'(wakeCause), 3);
    check("R9", "shutdown left", 32'(shutdownOut), 0);
    tick();
    tripleFault = 1;
    tick();
    tripleFault = 0;
    check("R8", "shutdown again", 32'(shutdownOut), 1);
    resetReq = 1;
    tick();
    resetReq = 0;
    check("R10", "reset leaves shutdown", 32'(shutdownOut), 0);
    check("R10", "reset cause", 32'(wakeCause), 1);
    check("R10", "reset resume", resumeIp, RVEC);
    tick();
    resetReq = 1;
    tick();
    resetReq = 0;
    check("R10", "reset in run wakes", 32'(wakeValid), 1);
    tick();
  endtask

  initial begin
    #5;
    tReset();
    rst_n = 1;
    tick();
    tReset();
    tHaltIntr();
    tNoSuspendNmi();
    tAckInRun();
    tPriority();
    tPendingDuringAck();
    tShutdown();
    finishRun();
  end

endmodule